// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Gate

This block keeps the status byte of a serial NOR flash and acts as the gate for every request that would change the array or the status byte. A command decoder upstream hands it one decoded request per cycle. Each request carries an operation code, a 24-bit-style array address and a data byte. The block answers one cycle later with a single-cycle `grant` or `deny` pulse. When a request is granted, the array sequencer downstream starts its internal cycle and later reports the end of that cycle on `cycle_done`.

The status byte holds several fields. A busy flag shows that an internal cycle is running. A write-enable latch must be set before any modifying request is accepted. A three-bit protection code fences off a region at the top of the array. A lock bit works with the active-low guard pin: when the lock bit is set and the pin is low, the lock bit and the protection code are frozen. A bulk erase is accepted only when no region is fenced. The status byte is visible on `status` at all times, including while a cycle is running.

Top module: `srwp_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `status` reads 0x00 and `grant` and `deny` are low.
- R2: `status` bit 0 is the busy flag, bit 1 the write-enable latch, bits 4:2 the protection code and bit 7 the lock bit. Bits 6:5 always read 0.
- R3: `req_op` codes are 0 idle, 1 latch set, 2 latch clear, 3 status write, 4 page write, 5 page program, 6 sector erase, 7 bulk erase. Latch set and latch clear are always granted and set or clear bit 1.
- R4: A status write, page write, page program, sector erase or bulk erase that arrives while the latch is 0 is denied and changes no status bit.
- R5: A status write with the latch set is granted when the lock bit is 0 or `hw_guard_n` is high. It loads bit 7 and bits 4:2 from `req_data` bits 7 and 4:2, ignores data bits 6, 5, 1 and 0, and sets the busy flag.
- R6: When the lock bit is 1 and `hw_guard_n` is low, a status write is denied. The lock bit and the protection code stay unchanged, and the latch is cleared.
- R7: Protection code n fences no sector when n is 0. Otherwise it fences the highest min(2^(n-1), sector count) sectors. The sector index is the address bits above bit 15 (bits 19:16 by default, 16 sectors).
- R8: A page write, page program or sector erase with the latch set is denied when its address lies in the fenced region. The latch is then cleared and the busy flag stays 0. Outside the region the request is granted and the busy flag is set.
- R9: A bulk erase with the latch set is granted only when the protection code is 000. Otherwise it is denied and the latch is cleared.
- R10: While the busy flag is 1, every request is dropped: no grant, no deny and no status change.
- R11: `cycle_done` while the busy flag is 1 clears both the busy flag and the latch. While idle it has no effect.
- R12: `grant` and `deny` are never high together. Each answer appears exactly one cycle after its request and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A decoded request is present this cycle |
| req_op | input | 3 | Operation code (see R3) |
| req_addr | input | ADDR_W (20) | Target array address |
| req_data | input | 8 | New status byte for a status write |
| hw_guard_n | input | 1 | Active-low hardware write-protect pin |
| cycle_done | input | 1 | Internal cycle finished (from the array sequencer) |
| status | output | 8 | Status byte |
| grant | output | 1 | Request accepted, one-cycle pulse |
| deny | output | 1 | Request refused, one-cycle pulse |

## Verification
Each protection code from 000 to 111 is loaded in turn. Sector erases are then aimed at the lowest, middle and topmost sectors, so that an error in the size of the fenced region shows up as a wrong answer at the sector boundary. Bulk erase is tried under every code, which separates code 000 from all other codes.

Status writes are issued with every combination of the lock bit and the guard pin, which separates the frozen case from the three writable ones. The data byte has its spare bits set, to show that those bits stay at zero. Requests sent while a cycle is running, and requests sent without the latch set, show that the busy flag and the latch each block a request on their own.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

    localparam int unsigned SR_BIT_BUSY  = 0;
    localparam int unsigned SR_BIT_LATCH = 1;
    localparam int unsigned SR_BIT_PC_LO = 2;
    localparam int unsigned SR_BIT_LOCK  = 7;
    localparam int unsigned PC_W         = 3;

    typedef enum logic [2:0] {
        OP_IDLE         = 3'd0,
        OP_LATCH_SET    = 3'd1,
        OP_LATCH_CLR    = 3'd2,
        OP_SR_WRITE     = 3'd3,
        OP_PAGE_WRITE   = 3'd4,
        OP_PAGE_PROG    = 3'd5,
        OP_SECTOR_ERASE = 3'd6,
        OP_BULK_ERASE   = 3'd7
    } op_e;

    typedef struct packed {
        logic            lock;
        logic [PC_W-1:0] pcode;
        logic            latch;
        logic            busy;
    } sr_state_t;

    typedef struct packed {
        logic grant;
        logic deny;
        logic set_latch;
        logic clr_latch;
        logic load_sr;
        logic start_cycle;
    } verdict_t;

    function automatic logic [7:0] pack_status(input sr_state_t s);
        logic [7:0] b;
        b = 8'h00;
        b[SR_BIT_BUSY]                     = s.busy;
        b[SR_BIT_LATCH]                    = s.latch;
        b[SR_BIT_PC_LO +: PC_W]            = s.pcode;
        b[SR_BIT_LOCK]                     = s.lock;
        return b;
    endfunction

    function automatic int unsigned fenced_count(input logic [PC_W-1:0] pc,
                                                 input int unsigned n_sect);
        int unsigned c;
        if (pc == '0) begin
            return 0;
        end
        c = 32'd1 << (int'(pc) - 1);
        return (c > n_sect) ? n_sect : c;
    endfunction

endpackage

// File: rtl/srwp_region.sv
module srwp_region
    import srwp_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int SECTOR_W = 16
) (
    input  logic [PC_W-1:0]        pcode,
    input  logic [ADDR_W-SECTOR_W-1:0] sector_idx,
    output logic                   in_region,
    output logic                   pcode_clear
);
    localparam int IDX_W = ADDR_W - SECTOR_W;
    localparam int N_SECT = 1 << IDX_W;

    int unsigned       cnt;
    logic [N_SECT-1:0] fence_mask;

    always_comb cnt = fenced_count(pcode, N_SECT);

    for (genvar g = 0; g < N_SECT; g++) begin : g_fence
        assign fence_mask[g] = (cnt != 0) && ((g + int'(cnt)) >= N_SECT);
    end

    assign in_region   = fence_mask[sector_idx];
    assign pcode_clear = (pcode == '0);

endmodule

// File: rtl/srwp_decide.sv
module srwp_decide
    import srwp_pkg::*;
(
    input  logic      req_valid,
    input  op_e       op,
    input  sr_state_t st,
    input  logic      hw_guard_n,
    input  logic      in_region,
    input  logic      pcode_clear,
    output verdict_t  v
);
    logic frozen;

    assign frozen = st.lock && !hw_guard_n;

    always_comb begin
        v = '0;
        if (req_valid && !st.busy) begin
            case (op)
                OP_LATCH_SET: begin
                    v.grant     = 1'b1;
                    v.set_latch = 1'b1;
                end
                OP_LATCH_CLR: begin
                    v.grant     = 1'b1;
                    v.clr_latch = 1'b1;
                end
                OP_SR_WRITE: begin
                    if (!st.latch) begin
                        v.deny = 1'b1;
                    end else if (frozen) begin
                        v.deny      = 1'b1;
                        v.clr_latch = 1'b1;
                    end else begin
                        v.grant       = 1'b1;
                        v.load_sr     = 1'b1;
                        v.start_cycle = 1'b1;
                    end
                end
                OP_PAGE_WRITE, OP_PAGE_PROG, OP_SECTOR_ERASE: begin
                    if (!st.latch) begin
                        v.deny = 1'b1;
                    end else if (in_region) begin
                        v.deny      = 1'b1;
                        v.clr_latch = 1'b1;
                    end else begin
                        v.grant       = 1'b1;
                        v.start_cycle = 1'b1;
                    end
                end
                OP_BULK_ERASE: begin
                    if (!st.latch) begin
                        v.deny = 1'b1;
                    end else if (!pcode_clear) begin
                        v.deny      = 1'b1;
                        v.clr_latch = 1'b1;
                    end else begin
                        v.grant       = 1'b1;
                        v.start_cycle = 1'b1;
                    end
                end
                default: v = '0;
            endcase
        end
    end

endmodule

// File: rtl/srwp_state.sv
module srwp_state
    import srwp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  verdict_t  v,
    input  logic [7:0] req_data,
    input  logic      cycle_done,
    output sr_state_t st,
    output logic      grant_q,
    output logic      deny_q
);
    logic unused_data;
    assign unused_data = ^{req_data[6:5], req_data[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
        end else begin
            grant_q <= v.grant;
            deny_q  <= v.deny;
            if (st.busy && cycle_done) begin
                st.busy  <= 1'b0;
                st.latch <= 1'b0;
            end else begin
                if (v.set_latch) st.latch <= 1'b1;
                if (v.clr_latch) st.latch <= 1'b0;
                if (v.load_sr) begin
                    st.lock  <= req_data[SR_BIT_LOCK];
                    st.pcode <= req_data[SR_BIT_PC_LO +: PC_W];
                end
                if (v.start_cycle) st.busy <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/srwp_ctrl.sv
module srwp_ctrl
    import srwp_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int SECTOR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              hw_guard_n,
    input  logic              cycle_done,
    output logic [7:0]        status,
    output logic              grant,
    output logic              deny
);
    sr_state_t st;
    verdict_t  v;
    logic      in_region;
    logic      pcode_clear;
    logic      unused_low;

    assign unused_low = ^req_addr[SECTOR_W-1:0];

    srwp_region #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W)) u_region (
        .pcode       (st.pcode),
        .sector_idx  (req_addr[ADDR_W-1:SECTOR_W]),
        .in_region   (in_region),
        .pcode_clear (pcode_clear)
    );

    srwp_decide u_decide (
        .req_valid   (req_valid),
        .op          (op_e'(req_op)),
        .st          (st),
        .hw_guard_n  (hw_guard_n),
        .in_region   (in_region),
        .pcode_clear (pcode_clear),
        .v           (v)
    );

    srwp_state u_state (
        .clk        (clk),
        .rst        (rst),
        .v          (v),
        .req_data   (req_data),
        .cycle_done (cycle_done),
        .st         (st),
        .grant_q    (grant),
        .deny_q     (deny)
    );

    assign status = pack_status(st);

endmodule

// File: rtl/srwp_checker.sv
module srwp_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic [7:0] req_data,
    input logic       hw_guard_n,
    input logic       cycle_done,
    input logic [7:0] status,
    input logic       grant,
    input logic       deny
);
    p_spare_zero_r2: assert property (@(posedge clk) disable iff (rst)
        status[6:5] == 2'b00);

    p_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
        !(grant && deny));

    p_busy_drops_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && status[0]) |=> (!grant && !deny));

    p_latch_needed_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !status[0] && !status[1] && req_op >= 3'd3)
        |=> (deny && !grant));

    p_sr_load_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd3 && !status[0] && status[1]
         && (!status[7] || hw_guard_n))
        |=> (grant && status[0] && status[7] == $past(req_data[7])
             && status[4:2] == $past(req_data[4:2])));

    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd3 && !status[0] && status[1]
         && status[7] && !hw_guard_n)
        |=> (deny && !status[1] && $stable(status[7]) && $stable(status[4:2])));

    p_bulk_guard_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd7 && !status[0] && status[1]
         && status[4:2] != 3'b000)
        |=> (deny && !status[1] && !status[0]));

    p_done_clears_r11: assert property (@(posedge clk) disable iff (rst)
        (status[0] && cycle_done) |=> (!status[0] && !status[1]));

endmodule

bind srwp_ctrl srwp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_data   (req_data),
    .hw_guard_n (hw_guard_n),
    .cycle_done (cycle_done),
    .status     (status),
    .grant      (grant),
    .deny       (deny)
);

// File: tb/srwp_ctrl_bench.sv
module srwp_ctrl_bench;

    localparam logic [2:0] C_IDLE = 3'd0, C_LSET = 3'd1, C_LCLR = 3'd2, C_SRW = 3'd3,
                           C_PW = 3'd4, C_PP = 3'd5, C_SE = 3'd6, C_BE = 3'd7;

    typedef struct {
        logic       g;
        logic       d;
        logic [7:0] s;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        hw_guard_n = 1'b1;
    logic        cycle_done = 1'b0;
    logic [7:0]  status;
    logic        grant;
    logic        deny;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    bit   finished = 0;

    logic       m_lock = 0, m_latch = 0, m_busy = 0;
    logic [2:0] m_pc = 0;

    always #2 clk = ~clk;

    srwp_ctrl u_srwp_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .hw_guard_n(hw_guard_n),
        .cycle_done(cycle_done), .status(status), .grant(grant), .deny(deny)
    );

    function automatic bit fenced(input logic [2:0] pc, input logic [19:0] a);
        int cnt;
        if (pc == 0) return 0;
        cnt = (pc >= 5) ? 16 : (1 << (pc - 1));
        return int'(a[19:16]) >= 16 - cnt;
    endfunction

    task automatic step(input logic [2:0] op, input logic [19:0] addr,
                        input logic [7:0] data, input logic pin_n,
                        input logic done, input string tag);
        exp_t e;
        logic g = 0, d = 0;
        @(negedge clk);
        req_valid  = (op != C_IDLE);
        req_op     = op;
        req_addr   = addr;
        req_data   = data;
        hw_guard_n = pin_n;
        cycle_done = done;
        if (m_busy) begin
            if (done) begin
                m_busy = 0;
                m_latch = 0;
            end
        end else begin
            case (op)
                C_LSET: begin g = 1; m_latch = 1; end
                C_LCLR: begin g = 1; m_latch = 0; end
                C_SRW: begin
                    if (!m_latch) d = 1;
                    else if (m_lock && !pin_n) begin d = 1; m_latch = 0; end
                    else begin g = 1; m_lock = data[7]; m_pc = data[4:2]; m_busy = 1; end
                end
                C_PW, C_PP, C_SE: begin
                    if (!m_latch) d = 1;
                    else if (fenced(m_pc, addr)) begin d = 1; m_latch = 0; end
                    else begin g = 1; m_busy = 1; end
                end
                C_BE: begin
                    if (!m_latch) d = 1;
                    else if (m_pc != 0) begin d = 1; m_latch = 0; end
                    else begin g = 1; m_busy = 1; end
                end
                default: ;
            endcase
        end
        e.g = g;
        e.d = d;
        e.s = {m_lock, 2'b00, m_pc, m_latch, m_busy};
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: one expected item per stepped cycle, sampled after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (grant !== e.g || deny !== e.d || status !== e.s) begin
                    errors++;
                    $display("FAIL %s: got grant=%b deny=%b status=%h, expected grant=%b deny=%b status=%h",
                             e.tag, grant, deny, status, e.g, e.d, e.s);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int secs[6] = '{0, 7, 8, 12, 14, 15};
        repeat (3) @(negedge clk);
        checks++;
        if (status !== 8'h00 || grant !== 1'b0 || deny !== 1'b0) begin
            errors++;
            $display("FAIL R1: got status=%h grant=%b deny=%b, expected 00 0 0", status, grant, deny);
        end
        rst = 1'b0;
        step(C_IDLE, 0, 0, 1, 0, "R1 idle after reset");

        step(C_SRW, 0, 8'h9C, 1, 0, "R4 status write without latch");
        step(C_PP, 20'h12345, 0, 1, 0, "R4 page program without latch");
        step(C_BE, 0, 0, 1, 0, "R4 bulk erase without latch");

        step(C_LSET, 0, 0, 1, 0, "R3 latch set");
        step(C_LCLR, 0, 0, 1, 0, "R3 latch clear");
        step(C_LSET, 0, 0, 1, 0, "R3 latch set again");
        step(C_SRW, 0, 8'hFF, 1, 0, "R5 R2 status write spare bits");
        step(C_IDLE, 0, 0, 1, 0, "R12 pulse ends");
        step(C_LCLR, 0, 0, 1, 0, "R10 request while busy");
        step(C_SE, 20'h00000, 0, 1, 0, "R10 erase while busy");
        step(C_IDLE, 0, 0, 1, 1, "R11 cycle done");
        step(C_IDLE, 0, 0, 1, 1, "R11 done while idle");

        step(C_LSET, 0, 0, 0, 0, "R3 latch set");
        step(C_SRW, 0, 8'h00, 0, 0, "R6 frozen status write");
        step(C_LSET, 0, 0, 1, 0, "R3 latch set");
        step(C_SRW, 0, 8'h88, 1, 0, "R5 lock set pin high");
        step(C_IDLE, 0, 0, 1, 1, "R11 done");
        step(C_LSET, 0, 0, 1, 0, "R3 latch set");
        step(C_SRW, 0, 8'h08, 1, 0, "R5 lock clear pin high");
        step(C_IDLE, 0, 0, 1, 1, "R11 done");
        step(C_LSET, 0, 0, 0, 0, "R3 latch set");
        step(C_SRW, 0, 8'h84, 0, 0, "R5 lock 0 pin low writable");
        step(C_IDLE, 0, 0, 0, 1, "R11 done");
        step(C_LSET, 0, 0, 0, 0, "R3 latch set");
        step(C_SRW, 0, 8'h00, 0, 0, "R6 frozen again");
        step(C_LSET, 0, 0, 1, 0, "R3 latch set");
        step(C_SRW, 0, 8'h08, 1, 0, "R5 unlock code 2");
        step(C_IDLE, 0, 0, 1, 1, "R11 done");

        step(C_LSET, 0, 0, 1, 0, "R3 latch set");
        step(C_PW, 20'hEFFFF, 0, 1, 0, "R8 page write fenced sector 14");
        step(C_LSET, 0, 0, 1, 0, "R3 latch set");
        step(C_PP, 20'hDFFFF, 0, 1, 0, "R8 page program open sector 13");
        step(C_IDLE, 0, 0, 1, 1, "R11 done");
        step(C_LSET, 0, 0, 1, 0, "R3 latch set");
        step(C_PP, 20'hF0000, 0, 1, 0, "R8 page program fenced sector 15");

        for (int c = 0; c < 8; c++) begin
            step(C_LSET, 0, 0, 1, 0, "R3 latch set");
            step(C_SRW, 0, {3'b000, c[2:0], 2'b00}, 1, 0, "R5 load code");
            step(C_IDLE, 0, 0, 1, 1, "R11 done");
            foreach (secs[i]) begin
                step(C_LSET, 0, 0, 1, 0, "R3 latch set");
                step(C_SE, {secs[i][3:0], 16'h8000}, 0, 1, 0, "R7 R8 sector erase vs code");
                step(C_IDLE, 0, 0, 1, 1, "R11 done");
            end
            step(C_LSET, 0, 0, 1, 0, "R3 latch set");
            step(C_BE, 0, 0, 1, 0, "R9 bulk erase vs code");
            step(C_IDLE, 0, 0, 1, 1, "R11 done");
        end

        step(C_IDLE, 0, 0, 1, 0, "R12 final idle");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule